// File: doc/BRIEF.md
# Instruction Fetch Stage Controller

This block is the per-cycle control machine that sits beside the instruction fetch datapath of a pipelined out-of-order core. Each clock it looks at squash requests from the commit and decode stages, a flag saying the reorder buffer is still flushing, stall flags from the four downstream stages, the result of the current instruction-cache access and a miss-completion pulse. From these it decides whether fetch runs, whether the PC is redirected, whether an outstanding miss is cancelled and which branch-predictor maintenance strobes go out.

The conflicts are settled by a fixed priority. A commit squash wins. A lingering reorder-buffer flush comes next, then a decode squash, then the stall flags, then the blocked-to-running step, and last the fetch itself. An access that misses parks the controller in a wait state. The completion pulse moves it to a line-ready state, and there the next fetch takes the returned line without a new access. All control inputs are sampled on the rising clock edge. Every output is registered and so shows the decision one cycle after the inputs that caused it.

Top module: `fetch_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the state to Idle and clears the three cycle counters and every strobe. The state codes on `state_o` are Idle=0, Running=1, Squashing=2, Blocked=3, MissWait=4 and MissReady=5. After reset `pc_o` is RESET_PC and `npc_o` is RESET_PC+INST_BYTES.
- R2: A commit squash overrides every other input. It redirects to `cmt_pc_i`, enters Squashing, adds one to the squash counter, sends a predictor squash tagged `cmt_seq_i`, and does not fetch.
- R3: A predictor squash carries a correction (`bp_fix_o`=1 with the source's redirect PC and taken bit) only when that source flags a mispredict. Otherwise the correction fields read zero.
- R4: In any cycle without a commit squash, a nonzero `cmt_seq_i` issues a predictor update strobe carrying that number.
- R5: With no commit squash and the reorder buffer still flushing, the controller enters or stays in Squashing and counts a squash cycle. It does not fetch, does not redirect, and issues no predictor squash for a decode squash in that cycle.
- R6: If neither R2 nor R5 applies, a decode squash always sends a predictor squash tagged `dec_seq_i`. It redirects to `dec_pc_i`, enters Squashing and counts a squash cycle only when the state is not already Squashing.
- R7: Once R2, R5 and a redirecting decode squash are ruled out, any high stall flag makes the state Blocked whatever it was, counts a blocked cycle and prevents fetch.
- R8: In Blocked with nothing else pending, the state moves to Running with no fetch that cycle, and the cycle is still counted as blocked.
- R9: In Idle, Running or Squashing with nothing pending, the controller fetches. It raises `fetch_o` and `access_o` and counts a fetch cycle. If the access neither faults nor misses, it moves to Running and loads `fetch_next_pc_i` into `pc_o`.
- R10: A fetch access that misses enters MissWait and leaves the PC unchanged. MissWait never fetches. A completion pulse there moves it to MissReady. From MissReady the next fetch has `access_o`=0, takes the PC step and returns to Running.
- R11: A redirect made while in MissWait also raises `miss_cancel_o`. No other redirect raises it.
- R12: Whenever the PC is loaded, `npc_o` equals the new PC plus INST_BYTES.
- R13: A fetch access that faults enters Blocked and leaves the PC unchanged. A fault takes precedence over a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmt_squash_i | input | 1 | Squash request from commit |
| cmt_pc_i | input | AW | Commit redirect PC |
| cmt_seq_i | input | SW | Commit completed sequence number |
| cmt_mispredict_i | input | 1 | Commit reports a branch mispredict |
| cmt_taken_i | input | 1 | Commit branch outcome |
| rob_squashing_i | input | 1 | Reorder buffer still flushing |
| dec_squash_i | input | 1 | Squash request from decode |
| dec_pc_i | input | AW | Decode redirect PC |
| dec_seq_i | input | SW | Decode sequence number |
| dec_mispredict_i | input | 1 | Decode reports a branch mispredict |
| dec_taken_i | input | 1 | Decode branch outcome |
| stall_dec_i | input | 1 | Decode stall |
| stall_ren_i | input | 1 | Rename stall |
| stall_exe_i | input | 1 | Execute stall |
| stall_cmt_i | input | 1 | Commit stall |
| fetch_next_pc_i | input | AW | PC after the block fetched this cycle |
| line_miss_i | input | 1 | This cycle's cache access missed |
| fetch_fault_i | input | 1 | This cycle's access faulted |
| miss_done_i | input | 1 | Outstanding miss has completed |
| state_o | output | 3 | Current state code |
| fetch_o | output | 1 | A fetch took place |
| access_o | output | 1 | The fetch issued a cache access |
| redirect_o | output | 1 | PC was redirected by a squash |
| pc_o | output | AW | Current fetch PC |
| npc_o | output | AW | Following PC |
| miss_cancel_o | output | 1 | Cancel the outstanding miss |
| bp_squash_o | output | 1 | Predictor squash strobe |
| bp_squash_seq_o | output | SW | Sequence number for the squash |
| bp_fix_o | output | 1 | Squash carries a correction |
| bp_fix_pc_o | output | AW | Corrected target |
| bp_fix_taken_o | output | 1 | Corrected direction |
| bp_update_o | output | 1 | Predictor update strobe |
| bp_update_seq_o | output | SW | Sequence number for the update |
| cnt_squash_o | output | CW | Squash cycles |
| cnt_blocked_o | output | CW | Blocked cycles |
| cnt_fetch_o | output | CW | Fetch cycles |

## Verification
The states hardest to reach from the ports are MissReady and the miss cancel. The first needs a missing access, a completion pulse in a cycle free of squash and stall, and then another quiet cycle. The second needs a squash to land while a miss is outstanding. Directed sequences build both chains on purpose. Random stimulus then keeps squash and stall probabilities low, so that miss-wait episodes survive long enough for completions and late squashes to meet them in varied orders.

// File: rtl/fetch_ctrl_pkg.sv
package fetch_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RUN        = 3'd1,
    ST_SQUASH     = 3'd2,
    ST_BLOCKED    = 3'd3,
    ST_MISS_WAIT  = 3'd4,
    ST_MISS_READY = 3'd5
  } fstate_e;

  // per-cycle decision bits from the arbiter
  typedef struct packed {
    logic fetch;
    logic access;
    logic redir;
    logic redir_cmt;
    logic cancel;
    logic bp_sq;
    logic bp_cmt;
    logic bp_fix;
    logic bp_upd;
    logic advance;
  } fctl_s;

  localparam int NUM_CNT   = 3;
  localparam int CNT_SQ    = 0;
  localparam int CNT_BLK   = 1;
  localparam int CNT_FETCH = 2;

endpackage

// File: rtl/fetch_ctrl_arbiter.sv
module fetch_ctrl_arbiter
  import fetch_ctrl_pkg::*;
(
  input  fstate_e                 state_i,
  input  logic                    cmt_squash_i,
  input  logic                    cmt_mispredict_i,
  input  logic                    cmt_seq_nz_i,
  input  logic                    rob_squashing_i,
  input  logic                    dec_squash_i,
  input  logic                    dec_mispredict_i,
  input  logic                    any_stall_i,
  input  logic                    line_miss_i,
  input  logic                    fetch_fault_i,
  input  logic                    miss_done_i,
  output fstate_e                 nxt_state_o,
  output fctl_s                   ctl_o,
  output logic [NUM_CNT-1:0]      cnt_inc_o
);

  always_comb begin
    ctl_o       = '0;
    cnt_inc_o   = '0;
    nxt_state_o = state_i;
    if (cmt_squash_i) begin
      ctl_o.redir     = 1'b1;
      ctl_o.redir_cmt = 1'b1;
      ctl_o.cancel    = (state_i == ST_MISS_WAIT);
      ctl_o.bp_sq     = 1'b1;
      ctl_o.bp_cmt    = 1'b1;
      ctl_o.bp_fix    = cmt_mispredict_i;
      cnt_inc_o[CNT_SQ] = 1'b1;
      nxt_state_o     = ST_SQUASH;
    end else begin
      ctl_o.bp_upd = cmt_seq_nz_i;
      if (rob_squashing_i) begin
        cnt_inc_o[CNT_SQ] = 1'b1;
        nxt_state_o       = ST_SQUASH;
      end else begin
        if (dec_squash_i) begin
          ctl_o.bp_sq  = 1'b1;
          ctl_o.bp_fix = dec_mispredict_i;
        end
        if (dec_squash_i && state_i != ST_SQUASH) begin
          ctl_o.redir       = 1'b1;
          ctl_o.cancel      = (state_i == ST_MISS_WAIT);
          cnt_inc_o[CNT_SQ] = 1'b1;
          nxt_state_o       = ST_SQUASH;
        end else if (any_stall_i) begin
          cnt_inc_o[CNT_BLK] = 1'b1;
          nxt_state_o        = ST_BLOCKED;
        end else if (state_i == ST_BLOCKED) begin
          cnt_inc_o[CNT_BLK] = 1'b1;
          nxt_state_o        = ST_RUN;
        end else if (state_i == ST_MISS_WAIT) begin
          if (miss_done_i) nxt_state_o = ST_MISS_READY;
        end else begin
          ctl_o.fetch          = 1'b1;
          cnt_inc_o[CNT_FETCH] = 1'b1;
          if (state_i == ST_MISS_READY) begin
            ctl_o.advance = 1'b1;
            nxt_state_o   = ST_RUN;
          end else begin
            ctl_o.access = 1'b1;
            if (fetch_fault_i) begin
              nxt_state_o = ST_BLOCKED;
            end else if (line_miss_i) begin
              nxt_state_o = ST_MISS_WAIT;
            end else begin
              ctl_o.advance = 1'b1;
              nxt_state_o   = ST_RUN;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/fetch_ctrl_counters.sv
module fetch_ctrl_counters #(
  parameter int CW = 16,
  parameter int N  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  inc_i,
  output logic [CW-1:0] cnt_o [N]
);

  localparam logic [CW-1:0] ONE = CW'(1);

  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)           cnt_o[g] <= '0;
      else if (inc_i[g]) cnt_o[g] <= cnt_o[g] + ONE;
    end
  end

endmodule

// File: rtl/fetch_ctrl_pc.sv
module fetch_ctrl_pc #(
  parameter int          AW         = 32,
  parameter int          INST_BYTES = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redir_i,
  input  logic [AW-1:0] redir_pc_i,
  input  logic          advance_i,
  input  logic [AW-1:0] next_pc_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] npc_o
);

  localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o  <= RESET_PC;
      npc_o <= RESET_PC + STEP;
    end else if (redir_i) begin
      pc_o  <= redir_pc_i;
      npc_o <= redir_pc_i + STEP;
    end else if (advance_i) begin
      pc_o  <= next_pc_i;
      npc_o <= next_pc_i + STEP;
    end
  end

endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_ctrl_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            SW         = 16,
  parameter int            CW         = 16,
  parameter int            INST_BYTES = 4,
  parameter logic [AW-1:0] RESET_PC   = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmt_squash_i,
  input  logic [AW-1:0] cmt_pc_i,
  input  logic [SW-1:0] cmt_seq_i,
  input  logic          cmt_mispredict_i,
  input  logic          cmt_taken_i,
  input  logic          rob_squashing_i,
  input  logic          dec_squash_i,
  input  logic [AW-1:0] dec_pc_i,
  input  logic [SW-1:0] dec_seq_i,
  input  logic          dec_mispredict_i,
  input  logic          dec_taken_i,
  input  logic          stall_dec_i,
  input  logic          stall_ren_i,
  input  logic          stall_exe_i,
  input  logic          stall_cmt_i,
  input  logic [AW-1:0] fetch_next_pc_i,
  input  logic          line_miss_i,
  input  logic          fetch_fault_i,
  input  logic          miss_done_i,
  output logic [2:0]    state_o,
  output logic          fetch_o,
  output logic          access_o,
  output logic          redirect_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] npc_o,
  output logic          miss_cancel_o,
  output logic          bp_squash_o,
  output logic [SW-1:0] bp_squash_seq_o,
  output logic          bp_fix_o,
  output logic [AW-1:0] bp_fix_pc_o,
  output logic          bp_fix_taken_o,
  output logic          bp_update_o,
  output logic [SW-1:0] bp_update_seq_o,
  output logic [CW-1:0] cnt_squash_o,
  output logic [CW-1:0] cnt_blocked_o,
  output logic [CW-1:0] cnt_fetch_o
);

  fstate_e            state_q, state_d;
  fctl_s              ctl;
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CW-1:0]      cnt [NUM_CNT];
  logic [AW-1:0]      redir_pc;
  logic               any_stall;

  assign any_stall = stall_dec_i | stall_ren_i | stall_exe_i | stall_cmt_i;
  assign redir_pc  = ctl.redir_cmt ? cmt_pc_i : dec_pc_i;

  fetch_ctrl_arbiter u_arb (
    .state_i          (state_q),
    .cmt_squash_i     (cmt_squash_i),
    .cmt_mispredict_i (cmt_mispredict_i),
    .cmt_seq_nz_i     (|cmt_seq_i),
    .rob_squashing_i  (rob_squashing_i),
    .dec_squash_i     (dec_squash_i),
    .dec_mispredict_i (dec_mispredict_i),
    .any_stall_i      (any_stall),
    .line_miss_i      (line_miss_i),
    .fetch_fault_i    (fetch_fault_i),
    .miss_done_i      (miss_done_i),
    .nxt_state_o      (state_d),
    .ctl_o            (ctl),
    .cnt_inc_o        (cnt_inc)
  );

  fetch_ctrl_pc #(.AW(AW), .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC)) u_pc (
    .clk        (clk),
    .rst        (rst),
    .redir_i    (ctl.redir),
    .redir_pc_i (redir_pc),
    .advance_i  (ctl.advance),
    .next_pc_i  (fetch_next_pc_i),
    .pc_o       (pc_o),
    .npc_o      (npc_o)
  );

  fetch_ctrl_counters #(.CW(CW), .N(NUM_CNT)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc_i (cnt_inc),
    .cnt_o (cnt)
  );

  assign cnt_squash_o  = cnt[CNT_SQ];
  assign cnt_blocked_o = cnt[CNT_BLK];
  assign cnt_fetch_o   = cnt[CNT_FETCH];
  assign state_o       = state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q         <= ST_IDLE;
      fetch_o         <= 1'b0;
      access_o        <= 1'b0;
      redirect_o      <= 1'b0;
      miss_cancel_o   <= 1'b0;
      bp_squash_o     <= 1'b0;
      bp_squash_seq_o <= '0;
      bp_fix_o        <= 1'b0;
      bp_fix_pc_o     <= '0;
      bp_fix_taken_o  <= 1'b0;
      bp_update_o     <= 1'b0;
      bp_update_seq_o <= '0;
    end else begin
      state_q         <= state_d;
      fetch_o         <= ctl.fetch;
      access_o        <= ctl.access;
      redirect_o      <= ctl.redir;
      miss_cancel_o   <= ctl.cancel;
      bp_squash_o     <= ctl.bp_sq;
      bp_squash_seq_o <= !ctl.bp_sq ? '0 : (ctl.bp_cmt ? cmt_seq_i : dec_seq_i);
      bp_fix_o        <= ctl.bp_fix;
      bp_fix_pc_o     <= !ctl.bp_fix ? '0 : (ctl.bp_cmt ? cmt_pc_i : dec_pc_i);
      bp_fix_taken_o  <= ctl.bp_fix & (ctl.bp_cmt ? cmt_taken_i : dec_taken_i);
      bp_update_o     <= ctl.bp_upd;
      bp_update_seq_o <= ctl.bp_upd ? cmt_seq_i : '0;
    end
  end

endmodule

// File: rtl/fetch_ctrl_chk.sv
module fetch_ctrl_chk
  import fetch_ctrl_pkg::*;
#(
  parameter int AW         = 32,
  parameter int INST_BYTES = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cmt_squash_i,
  input logic [AW-1:0] cmt_pc_i,
  input logic          rob_squashing_i,
  input logic          dec_squash_i,
  input logic          any_stall,
  input logic          fetch_fault_i,
  input logic [2:0]    state_o,
  input logic          fetch_o,
  input logic          access_o,
  input logic          redirect_o,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] npc_o,
  input logic          miss_cancel_o
);

  logic quiet;
  assign quiet = !cmt_squash_i && !rob_squashing_i && !dec_squash_i && !any_stall;

  AST_CMT_SQUASH_WINS: assert property (@(posedge clk) disable iff (rst)
    cmt_squash_i |=> (state_o == ST_SQUASH && redirect_o && !fetch_o && pc_o == $past(cmt_pc_i))); // R2

  AST_ROB_HOLDS_SQUASH: assert property (@(posedge clk) disable iff (rst)
    (!cmt_squash_i && rob_squashing_i) |=> (state_o == ST_SQUASH && !fetch_o && !redirect_o)); // R5

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!cmt_squash_i && !rob_squashing_i && !(dec_squash_i && state_o != ST_SQUASH) && any_stall)
      |=> (state_o == ST_BLOCKED && !fetch_o)); // R7

  AST_UNBLOCK_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (quiet && state_o == ST_BLOCKED) |=> (state_o == ST_RUN && !fetch_o)); // R8

  AST_MISS_WAIT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (quiet && state_o == ST_MISS_WAIT) |=> !fetch_o); // R10

  AST_READY_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (quiet && state_o == ST_MISS_READY) |=> (fetch_o && !access_o && state_o == ST_RUN)); // R10

  AST_CANCEL_ONLY_WAIT: assert property (@(posedge clk) disable iff (rst)
    miss_cancel_o |-> (redirect_o && $past(state_o) == ST_MISS_WAIT)); // R11

  AST_REDIRECT_NPC: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (npc_o == pc_o + AW'(INST_BYTES))); // R12

  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (quiet && fetch_fault_i && (state_o == ST_IDLE || state_o == ST_RUN || state_o == ST_SQUASH))
      |=> (state_o == ST_BLOCKED && access_o && pc_o == $past(pc_o))); // R13

endmodule

bind fetch_ctrl fetch_ctrl_chk #(.AW(AW), .INST_BYTES(INST_BYTES)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .cmt_squash_i    (cmt_squash_i),
  .cmt_pc_i        (cmt_pc_i),
  .rob_squashing_i (rob_squashing_i),
  .dec_squash_i    (dec_squash_i),
  .any_stall       (any_stall),
  .fetch_fault_i   (fetch_fault_i),
  .state_o         (state_o),
  .fetch_o         (fetch_o),
  .access_o        (access_o),
  .redirect_o      (redirect_o),
  .pc_o            (pc_o),
  .npc_o           (npc_o),
  .miss_cancel_o   (miss_cancel_o)
);

// File: tb/tb_fetch_ctrl.sv
`timescale 1ns/1ps
module tb_fetch_ctrl;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst;
  logic        cmt_squash_i, cmt_mispredict_i, cmt_taken_i, rob_squashing_i;
  logic [31:0] cmt_pc_i, dec_pc_i, fetch_next_pc_i;
  logic [15:0] cmt_seq_i, dec_seq_i;
  logic        dec_squash_i, dec_mispredict_i, dec_taken_i;
  logic        stall_dec_i, stall_ren_i, stall_exe_i, stall_cmt_i;
  logic        line_miss_i, fetch_fault_i, miss_done_i;
  logic [2:0]  state_o;
  logic        fetch_o, access_o, redirect_o, miss_cancel_o;
  logic [31:0] pc_o, npc_o, bp_fix_pc_o;
  logic        bp_squash_o, bp_fix_o, bp_fix_taken_o, bp_update_o;
  logic [15:0] bp_squash_seq_o, bp_update_seq_o;
  logic [15:0] cnt_squash_o, cnt_blocked_o, cnt_fetch_o;

  fetch_ctrl dut (.*);

  int total = 0;
  int fails = 0;
  bit done  = 0;

  // expected model
  int          m_st;
  logic [31:0] m_pc, m_npc, e_fixpc;
  logic [15:0] e_sqseq, e_updseq, c_sq, c_blk, c_f;
  logic        e_fetch, e_acc, e_redir, e_cancel, e_bpsq, e_fix, e_taken, e_upd;
  string       tag, tag_bp;

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_redirect(logic [31:0] p);
    e_redir = 1; e_cancel = (m_st == 4);
    m_pc = p; m_npc = p + 32'd4;
  endtask

  task automatic model_step();
    int ns;
    logic stall;
    e_fetch = 0; e_acc = 0; e_redir = 0; e_cancel = 0; e_bpsq = 0; e_fix = 0;
    e_taken = 0; e_fixpc = 0; e_sqseq = 0; e_upd = 0; e_updseq = 0; tag_bp = "R6";
    stall = stall_dec_i | stall_ren_i | stall_exe_i | stall_cmt_i;
    if (rst) begin
      tag = "R1"; m_st = 0; m_pc = 0; m_npc = 4; c_sq = 0; c_blk = 0; c_f = 0;
      return;
    end
    ns = m_st;
    if (cmt_squash_i) begin
      tag = "R2"; tag_bp = "R2";
      e_bpsq = 1; e_sqseq = cmt_seq_i; e_fix = cmt_mispredict_i;
      if (e_fix) begin e_fixpc = cmt_pc_i; e_taken = cmt_taken_i; end
      do_redirect(cmt_pc_i); c_sq++; ns = 2;
    end else begin
      if (cmt_seq_i != 0) begin e_upd = 1; e_updseq = cmt_seq_i; end
      if (rob_squashing_i) begin
        tag = "R5"; tag_bp = "R5"; c_sq++; ns = 2;
      end else begin
        if (dec_squash_i) begin
          e_bpsq = 1; e_sqseq = dec_seq_i; e_fix = dec_mispredict_i;
          if (e_fix) begin e_fixpc = dec_pc_i; e_taken = dec_taken_i; end
        end
        if (dec_squash_i && m_st != 2) begin
          tag = "R6"; do_redirect(dec_pc_i); c_sq++; ns = 2;
        end else if (stall) begin
          tag = "R7"; c_blk++; ns = 3;
        end else if (m_st == 3) begin
          tag = "R8"; c_blk++; ns = 1;
        end else if (m_st == 4) begin
          tag = "R10"; if (miss_done_i) ns = 5;
        end else begin
          e_fetch = 1; c_f++;
          if (m_st == 5) begin
            tag = "R10"; ns = 1; m_pc = fetch_next_pc_i; m_npc = m_pc + 32'd4;
          end else begin
            e_acc = 1;
            if (fetch_fault_i) begin tag = "R13"; ns = 3; end
            else if (line_miss_i) begin tag = "R10"; ns = 4; end
            else begin tag = "R9"; ns = 1; m_pc = fetch_next_pc_i; m_npc = m_pc + 32'd4; end
          end
        end
      end
    end
    m_st = ns;
  endtask

  task automatic compare();
    chk(tag, "state", 32'(state_o), 32'(m_st));
    chk(tag, "fetch", 32'(fetch_o), 32'(e_fetch));
    chk(tag, "access", 32'(access_o), 32'(e_acc));
    chk(tag, "redirect", 32'(redirect_o), 32'(e_redir));
    chk(tag, "pc", pc_o, m_pc);
    chk("R12", "npc", npc_o, m_npc);
    chk("R11", "cancel", 32'(miss_cancel_o), 32'(e_cancel));
    chk(tag_bp, "bp_squash", 32'(bp_squash_o), 32'(e_bpsq));
    chk(tag_bp, "bp_seq", 32'(bp_squash_seq_o), 32'(e_sqseq));
    chk("R3", "bp_fix", 32'(bp_fix_o), 32'(e_fix));
    chk("R3", "bp_fix_pc", bp_fix_pc_o, e_fixpc);
    chk("R3", "bp_fix_taken", 32'(bp_fix_taken_o), 32'(e_taken));
    chk("R4", "bp_update", 32'(bp_update_o), 32'(e_upd));
    chk("R4", "bp_update_seq", 32'(bp_update_seq_o), 32'(e_updseq));
    chk(tag, "cnt_squash", 32'(cnt_squash_o), 32'(c_sq));
    chk(tag, "cnt_blocked", 32'(cnt_blocked_o), 32'(c_blk));
    chk(tag, "cnt_fetch", 32'(cnt_fetch_o), 32'(c_f));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic quiet();
    cmt_squash_i = 0; cmt_mispredict_i = 0; cmt_taken_i = 0; cmt_seq_i = 0;
    rob_squashing_i = 0; dec_squash_i = 0; dec_mispredict_i = 0; dec_taken_i = 0;
    dec_seq_i = 0; stall_dec_i = 0; stall_ren_i = 0; stall_exe_i = 0; stall_cmt_i = 0;
    line_miss_i = 0; fetch_fault_i = 0; miss_done_i = 0;
    cmt_pc_i = 32'h1000; dec_pc_i = 32'h2000;
    fetch_next_pc_i = pc_o + 32'd16;
  endtask

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    rst = 1; quiet();
    tick(); tick();                                // R1 reset state
    rst = 0;
    quiet(); tick();                               // R9 fetch from Idle
    quiet(); line_miss_i = 1; tick();              // R10 miss -> MissWait
    quiet(); tick();                               // R10 waiting
    quiet(); miss_done_i = 1; tick();              // R10 -> MissReady
    quiet(); tick();                               // R10 fetch without access
    quiet(); line_miss_i = 1; tick();
    quiet(); cmt_squash_i = 1; cmt_mispredict_i = 1; cmt_taken_i = 1;
    cmt_pc_i = 32'h4440; cmt_seq_i = 16'h33; tick(); // R2 R3 R11
    quiet(); rob_squashing_i = 1; cmt_seq_i = 16'h7; tick(); // R5 R4
    quiet(); rob_squashing_i = 1; dec_squash_i = 1; tick();  // R5 ignores decode
    quiet(); dec_squash_i = 1; dec_seq_i = 16'h9; tick();    // R6 no redirect in Squashing
    quiet(); dec_squash_i = 1; dec_mispredict_i = 1; dec_taken_i = 1; tick(); // R6 R3
    quiet(); stall_exe_i = 1; tick();              // R7
    quiet(); tick();                               // R8
    quiet(); fetch_fault_i = 1; line_miss_i = 1; tick(); // R13
    quiet(); tick();
    quiet(); tick();
    for (int i = 0; i < 4000; i++) begin
      quiet();
      cmt_squash_i     = ($urandom % 20) == 0;
      cmt_mispredict_i = $urandom % 2;
      cmt_taken_i      = $urandom % 2;
      cmt_pc_i         = $urandom & 32'hFFFF_FFFC;
      cmt_seq_i        = (($urandom % 3) == 0) ? 16'($urandom) : 16'h0;
      rob_squashing_i  = ($urandom % 16) == 0;
      dec_squash_i     = ($urandom % 12) == 0;
      dec_mispredict_i = $urandom % 2;
      dec_taken_i      = $urandom % 2;
      dec_pc_i         = $urandom & 32'hFFFF_FFFC;
      dec_seq_i        = 16'($urandom);
      stall_dec_i      = ($urandom % 30) == 0;
      stall_ren_i      = ($urandom % 30) == 0;
      stall_exe_i      = ($urandom % 30) == 0;
      stall_cmt_i      = ($urandom % 30) == 0;
      line_miss_i      = ($urandom % 4) == 0;
      fetch_fault_i    = ($urandom % 25) == 0;
      miss_done_i      = ($urandom % 3) == 0;
      fetch_next_pc_i  = $urandom & 32'hFFFF_FFFC;
      rst              = (i == 2000);
      tick();
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule